// File: doc/BRIEF.md
# Warp Line Coalescer with Contention-Aware First-Level Bypass

This block takes one warp memory instruction, given as 32 lane byte addresses and an active-lane mask, and turns it into the smallest set of 128-byte line requests that covers every active lane. Each request also carries a per-instruction choice. The instruction either allocates its lines in the first-level cache, or it bypasses that cache and fetches only the 32-byte sectors it needs from the shared second level.

The choice compares two numbers. The first is the count of distinct 128-byte lines the instruction touches. The second is the share of first-level lines that one warp may claim: the total line count (512 by default) divided by the number of warps resident on the unit. That warp count is clamped to 64, and a count of zero means the full 512. An instruction that touches fewer lines than its share allocates. Any other instruction bypasses.

Control is a three-state machine:
- `ST_IDLE` waits for an instruction. Transition *accept*: `in_valid` is high with at least one active lane. Transition *empty*: `in_valid` is high with no active lane; the instruction is consumed and the machine stays in `ST_IDLE`.
- `ST_SCAN` extracts one new line per cycle and stores it. It takes the lowest-numbered pending lane as leader and retires every pending lane on the same line. Transition *scan_done*: no lanes remain pending. On this transition the bypass decision is latched and the machine moves to `ST_EMIT`.
- `ST_EMIT` presents one stored request per cycle. Transition *last*: the final request has been presented, and the machine returns to `ST_IDLE`.

Top module: `warp_line_coalescer`

## Requirements
- R1: `in_ready` is high exactly while the block is idle. After reset `in_ready` is 1 and `req_valid` is 0. An instruction is taken on a clock edge where both `in_valid` and `in_ready` are high. Asserting reset in the middle of an instruction returns the block to idle with no request pending.
- R2: An instruction yields one request per distinct line address among its active lanes, where the line address is `addr[31:7]`. No line is repeated and none is missing.
- R3: Requests are ordered by the lowest-numbered active lane that falls on each line.
- R4: The per-warp allowance is 512 divided by the resident warp count. A warp count above 64 is treated as 64, and a warp count of 0 gives an allowance of 512.
- R5: `req_bypass` is 0 (allocate) when the number of distinct lines is strictly less than the allowance. Otherwise it is 1 (bypass). All requests of one instruction carry the same value.
- R6: An allocating request has `req_sectors` = 4'b1111, so the full line is requested as four 32-byte pieces.
- R7: A bypassing request has bit k of `req_sectors` set exactly when some active lane on that line has `addr[6:5]` == k.
- R8: Lanes with a clear mask bit have no effect on the requests. An instruction with an all-zero mask produces no request and leaves the block ready in the next cycle.
- R9: The requests of one instruction appear on consecutive cycles. `req_last` is high on the final request only, and the block is idle in the cycle after it.
- R10: Take an instruction that touches N ≥ 1 lines and is accepted on edge A. Its first request is presented after edge A+N and its last request after edge A+2N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | Block is idle and takes the offered instruction |
| in_addr | input | 1024 | Lane byte addresses; lane i occupies bits [32i+31:32i] |
| in_mask | input | 32 | Active-lane mask; bit i enables lane i |
| in_warps | input | 7 | Number of warps currently resident on the unit |
| req_valid | output | 1 | A line request is presented this cycle |
| req_line | output | 25 | Line address (byte address bits 31:7) |
| req_sectors | output | 4 | 32-byte sectors needed within the line |
| req_bypass | output | 1 | 1 = bypass first level, 0 = allocate in first level |
| req_last | output | 1 | Final request of the current instruction |

## Verification
The hardest cases to reach are the edges of the comparison. In one, the line count equals the allowance exactly. In another, the warp count is zero or above the clamp. A third has lanes of one line spread over several sectors or in non-monotonic lane order. The vector table drives each of these from its ports. Each entry uses a linear lane address pattern, with base and stride chosen so that the number of distinct lines lands on, just below or just above the allowance. Some entries use a stride that is not a multiple of the line size, which scatters sector bits. A descending stride reverses the address order against the lane order. Directed cases then interleave two lines across alternating lanes and assert reset during a request burst.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_EMIT = 2'd2
    } coal_state_e;

endpackage

// File: rtl/coal_allowance.sv
// Per-warp share of first-level lines, with clamp and zero-warp guard.
module coal_allowance #(
    parameter int L1_LINES  = 512,
    parameter int MAX_WARPS = 64,
    parameter int WARP_W    = 7,
    localparam int ALLOW_W  = $clog2(L1_LINES + 1)
) (
    input  logic [WARP_W-1:0]  warps,
    output logic [ALLOW_W-1:0] allowance
);

    always_comb begin
        int w;
        w = int'(warps);
        if (w > MAX_WARPS) begin
            w = MAX_WARPS;
        end
        if (w == 0) begin
            allowance = ALLOW_W'(L1_LINES);
        end else begin
            allowance = ALLOW_W'(L1_LINES / w);
        end
    end

endmodule

// File: rtl/coal_leader_match.sv
// Picks the lowest pending lane, marks all pending lanes on its line,
// and gathers the sectors those lanes need.
module coal_leader_match #(
    parameter int LANES   = 32,
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 7,
    parameter int SEC_SH  = 5,
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int SEC_IW = OFF_W - SEC_SH,
    localparam int SEC_N  = 1 << SEC_IW
) (
    input  logic [ADDR_W-1:0] lane_addr [LANES],
    input  logic [LANES-1:0]  pending,
    output logic [LINE_W-1:0] leader_line,
    output logic [LANES-1:0]  match,
    output logic [SEC_N-1:0]  sectors
);

    logic [LINE_W-1:0] line_of [LANES];
    logic [SEC_IW-1:0] sec_of  [LANES];
    logic              unused_low;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign line_of[g] = lane_addr[g][ADDR_W-1:OFF_W];
        assign sec_of[g]  = lane_addr[g][OFF_W-1:SEC_SH];
        assign match[g]   = pending[g] && (line_of[g] == leader_line);
    end

    // byte offset inside a sector does not influence any request
    always_comb begin
        unused_low = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            unused_low = unused_low ^ (^lane_addr[i][SEC_SH-1:0]);
        end
    end

    // lowest-numbered pending lane wins: scan downward, last hit stays
    always_comb begin
        leader_line = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) begin
                leader_line = line_of[i];
            end
        end
    end

    always_comb begin
        sectors = '0;
        for (int i = 0; i < LANES; i++) begin
            if (match[i]) begin
                sectors[sec_of[i]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/coal_req_store.sv
// Holds the extracted lines of one instruction until they are emitted.
module coal_req_store #(
    parameter int DEPTH  = 32,
    parameter int WIDTH  = 29,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/warp_line_coalescer.sv
module warp_line_coalescer
    import coal_pkg::*;
#(
    parameter int LANES           = 32,
    parameter int ADDR_W          = 32,
    parameter int L1_LINE_BYTES   = 128,
    parameter int L2_SECTOR_BYTES = 32,
    parameter int L1_LINES        = 512,
    parameter int MAX_WARPS       = 64,
    parameter int WARP_W          = 7,
    localparam int OFF_W          = $clog2(L1_LINE_BYTES),
    localparam int SEC_SH         = $clog2(L2_SECTOR_BYTES),
    localparam int LINE_W         = ADDR_W - OFF_W,
    localparam int SEC_N          = L1_LINE_BYTES / L2_SECTOR_BYTES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]        in_mask,
    input  logic [WARP_W-1:0]       in_warps,
    output logic                    req_valid,
    output logic [LINE_W-1:0]       req_line,
    output logic [SEC_N-1:0]        req_sectors,
    output logic                    req_bypass,
    output logic                    req_last
);

    localparam int IDX_W   = $clog2(LANES);
    localparam int CNT_W   = $clog2(LANES + 1);
    localparam int ALLOW_W = $clog2(L1_LINES + 1);
    localparam int ENTRY_W = LINE_W + SEC_N;

    coal_state_e state_q, state_d;

    logic [ADDR_W-1:0]  addr_q [LANES];
    logic [LANES-1:0]   pending_q;
    logic [ALLOW_W-1:0] allow_q;
    logic [ALLOW_W-1:0] allow_now;
    logic [CNT_W-1:0]   count_q;
    logic [IDX_W-1:0]   emit_q;
    logic               bypass_q;

    logic [LINE_W-1:0]  leader_line;
    logic [LANES-1:0]   match;
    logic [SEC_N-1:0]   sectors;
    logic [LANES-1:0]   pending_next;
    logic [CNT_W-1:0]   count_inc;
    logic               accept;
    logic               scan_done;
    logic               emit_done;
    logic               over_quota;
    logic [ENTRY_W-1:0] rd_data;
    logic [SEC_N-1:0]   raw_sec;

    coal_allowance #(
        .L1_LINES (L1_LINES),
        .MAX_WARPS(MAX_WARPS),
        .WARP_W   (WARP_W)
    ) i_allowance (
        .warps    (in_warps),
        .allowance(allow_now)
    );

    coal_leader_match #(
        .LANES (LANES),
        .ADDR_W(ADDR_W),
        .OFF_W (OFF_W),
        .SEC_SH(SEC_SH)
    ) i_leader (
        .lane_addr  (addr_q),
        .pending    (pending_q),
        .leader_line(leader_line),
        .match      (match),
        .sectors    (sectors)
    );

    coal_req_store #(
        .DEPTH(LANES),
        .WIDTH(ENTRY_W)
    ) i_store (
        .clk    (clk),
        .wr_en  (state_q == ST_SCAN),
        .wr_idx (count_q[IDX_W-1:0]),
        .wr_data({leader_line, sectors}),
        .rd_idx (emit_q),
        .rd_data(rd_data)
    );

    assign accept       = in_valid && (state_q == ST_IDLE);
    assign pending_next = pending_q & ~match;
    assign count_inc    = count_q + 1'b1;
    assign scan_done    = (state_q == ST_SCAN) && (pending_next == '0);
    assign emit_done    = (state_q == ST_EMIT) && ((CNT_W'(emit_q) + CNT_W'(1)) == count_q);
    assign over_quota   = ALLOW_W'(count_inc) >= allow_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && (in_mask != '0)) state_d = ST_SCAN;
            ST_SCAN: if (scan_done)                 state_d = ST_EMIT;
            ST_EMIT: if (emit_done)                 state_d = ST_IDLE;
            default:                                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // lane address capture (no reset needed: gated by pending_q)
    always_ff @(posedge clk) begin
        if (accept) begin
            for (int i = 0; i < LANES; i++) begin
                addr_q[i] <= in_addr[i*ADDR_W +: ADDR_W];
            end
        end
    end

    // scan and emit bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
            allow_q   <= '0;
            count_q   <= '0;
            emit_q    <= '0;
            bypass_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        pending_q <= in_mask;
                        allow_q   <= allow_now;
                        count_q   <= '0;
                        emit_q    <= '0;
                        bypass_q  <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    pending_q <= pending_next;
                    count_q   <= count_inc;
                    if (scan_done) begin
                        bypass_q <= over_quota;
                    end
                end
                ST_EMIT: begin
                    emit_q <= emit_q + 1'b1;
                end
                default: begin
                    pending_q <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        {req_line, raw_sec} = rd_data;
        in_ready    = (state_q == ST_IDLE);
        req_valid   = (state_q == ST_EMIT);
        req_bypass  = req_valid && bypass_q;
        req_sectors = bypass_q ? raw_sec : '1;
        req_last    = emit_done;
    end

endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
    parameter int LANES  = 32,
    parameter int LINE_W = 25,
    parameter int SEC_N  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [LANES-1:0]  in_mask,
    input logic              req_valid,
    input logic [LINE_W-1:0] req_line,
    input logic [SEC_N-1:0]  req_sectors,
    input logic              req_bypass,
    input logic              req_last
);

    assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !in_ready);

    assert_distinct_adjacent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_last) |=> (req_line != $past(req_line)));

    assert_alloc_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_bypass) |-> (req_sectors == '1));

    assert_bypass_sectors_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_bypass) |-> (req_sectors != '0));

    assert_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_mask == '0)) |=> (in_ready && !req_valid));

    assert_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_last) |=> (req_valid && (req_bypass == $past(req_bypass))));

    assert_burst_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_last) |=> (!req_valid && in_ready));

endmodule

bind warp_line_coalescer coal_checker #(
    .LANES (LANES),
    .LINE_W(LINE_W),
    .SEC_N (SEC_N)
) i_coal_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_mask    (in_mask),
    .req_valid  (req_valid),
    .req_line   (req_line),
    .req_sectors(req_sectors),
    .req_bypass (req_bypass),
    .req_last   (req_last)
);

// File: tb/test_warp_line_coalescer.sv
`timescale 1ns/1ps
module test_warp_line_coalescer;

    localparam int LANES  = 32;
    localparam int ADDR_W = 32;
    localparam int LINE_W = 25;
    localparam int WARP_W = 7;
    localparam int NVEC   = 16;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] stride;
        logic [31:0] mask;
        logic [7:0]  warps;
        logic [5:0]  n;
        logic        byp;
    } vec_t;

    // base, stride, mask, resident warps, expected line count, expected bypass
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_1000, 32'd4,        32'hFFFF_FFFF, 8'd8,   6'd1,  1'b0},
        '{32'h0000_2000, 32'd128,      32'hFFFF_FFFF, 8'd16,  6'd32, 1'b1},
        '{32'h0000_2000, 32'd128,      32'hFFFF_FFFF, 8'd17,  6'd32, 1'b1},
        '{32'h0000_2000, 32'd128,      32'h7FFF_FFFF, 8'd16,  6'd31, 1'b0},
        '{32'h0000_4000, 32'd32,       32'hFFFF_FFFF, 8'd64,  6'd8,  1'b1},
        '{32'h0000_4000, 32'd32,       32'h00FF_FFFF, 8'd64,  6'd6,  1'b0},
        '{32'h0000_5000, 32'd128,      32'hFFFF_FFFF, 8'd0,   6'd32, 1'b0},
        '{32'h0000_3040, 32'd8,        32'h5555_5555, 8'd40,  6'd3,  1'b0},
        '{32'h0000_6020, 32'd160,      32'hFFFF_FFFF, 8'd64,  6'd32, 1'b1},
        '{32'h0000_7000, 32'hFFFF_FF80, 32'hFFFF_FFFF, 8'd100, 6'd32, 1'b1},
        '{32'h0000_8000, 32'd4,        32'h0000_0000, 8'd5,   6'd0,  1'b0},
        '{32'h0000_9060, 32'd32,       32'h0000_000F, 8'd64,  6'd2,  1'b0},
        '{32'h0000_B000, 32'd48,       32'hFFFF_FFFF, 8'd64,  6'd12, 1'b1},
        '{32'h0000_C000, 32'd128,      32'h8000_0000, 8'd1,   6'd1,  1'b0},
        '{32'h0000_F000, 32'd128,      32'h0000_00FF, 8'd63,  6'd8,  1'b1},
        '{32'h0000_F000, 32'd128,      32'h0000_007F, 8'd65,  6'd7,  1'b0}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                    rst_n;
    logic                    in_valid;
    logic                    in_ready;
    logic [LANES*ADDR_W-1:0] in_addr;
    logic [LANES-1:0]        in_mask;
    logic [WARP_W-1:0]       in_warps;
    logic                    req_valid;
    logic [LINE_W-1:0]       req_line;
    logic [3:0]              req_sectors;
    logic                    req_bypass;
    logic                    req_last;

    warp_line_coalescer i_warp_line_coalescer (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_addr    (in_addr),
        .in_mask    (in_mask),
        .in_warps   (in_warps),
        .req_valid  (req_valid),
        .req_line   (req_line),
        .req_sectors(req_sectors),
        .req_bypass (req_bypass),
        .req_last   (req_last)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [ADDR_W-1:0] lane_addr [LANES];
    logic [LINE_W-1:0] exp_line  [LANES];
    logic [3:0]        exp_sec   [LANES];
    int                exp_n;
    bit                exp_byp;
    logic [LINE_W-1:0] got_line  [LANES];
    logic [3:0]        got_sec   [LANES];
    bit                got_byp   [LANES];
    bit                got_last  [LANES];
    int                last_got;
    bit                last_byp;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // reference: distinct lines in lowest-lane order, sectors, quota decision
    task automatic model(input logic [LANES-1:0] mask, input int warps);
        int w;
        int allow;
        exp_n = 0;
        for (int l = 0; l < LANES; l++) begin
            if (mask[l]) begin
                int hit;
                hit = -1;
                for (int j = 0; j < exp_n; j++) begin
                    if (exp_line[j] == lane_addr[l][31:7]) hit = j;
                end
                if (hit < 0) begin
                    exp_line[exp_n] = lane_addr[l][31:7];
                    exp_sec[exp_n]  = 4'b0000;
                    hit = exp_n;
                    exp_n++;
                end
                exp_sec[hit][lane_addr[l][6:5]] = 1'b1;
            end
        end
        w     = (warps > 64) ? 64 : warps;
        allow = (w == 0) ? 512 : 512 / w;
        exp_byp = (exp_n >= allow);
        if (!exp_byp) begin
            for (int j = 0; j < exp_n; j++) exp_sec[j] = 4'b1111;
        end
    endtask

    task automatic run_instr(input string name, input logic [LANES-1:0] mask, input int warps);
        int got;
        int first;
        int lastc;
        model(mask, warps);
        @(negedge clk);
        check(in_ready === 1'b1, "R1", {name, " ready before offer"}, 64'(in_ready), 64'd1);
        for (int l = 0; l < LANES; l++) in_addr[l*ADDR_W +: ADDR_W] = lane_addr[l];
        in_mask  = mask;
        in_warps = WARP_W'(warps);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        got = 0; first = -1; lastc = -1;
        if (exp_n > 0)
            check(in_ready === 1'b0, "R1", {name, " busy after accept"}, 64'(in_ready), 64'd0);
        for (int cyc = 1; cyc <= 80; cyc++) begin
            if (req_valid === 1'b1) begin
                if (got < LANES) begin
                    got_line[got] = req_line;
                    got_sec[got]  = req_sectors;
                    got_byp[got]  = req_bypass;
                    got_last[got] = req_last;
                end
                if (first < 0) first = cyc;
                got++;
                lastc = cyc;
                if (req_last === 1'b1) break;
            end
            if (exp_n == 0 && cyc == 4) break;
            @(negedge clk);
        end
        check(got == exp_n, "R2", {name, " request count"}, 64'(got), 64'(exp_n));
        if (exp_n == 0) begin
            check(in_ready === 1'b1, "R8", {name, " ready after empty mask"}, 64'(in_ready), 64'd1);
        end else begin
            check(first == exp_n + 1, "R10", {name, " first request cycle"}, 64'(first), 64'(exp_n + 1));
            check(lastc - first + 1 == got, "R9", {name, " back-to-back requests"},
                  64'(lastc - first + 1), 64'(got));
        end
        for (int i = 0; i < exp_n && i < got && i < LANES; i++) begin
            check(got_line[i] == exp_line[i], "R3", {name, " line order"}, 64'(got_line[i]), 64'(exp_line[i]));
            check(got_sec[i] == exp_sec[i], exp_byp ? "R7" : "R6", {name, " sectors"},
                  64'(got_sec[i]), 64'(exp_sec[i]));
            check(got_byp[i] == exp_byp, "R5", {name, " bypass flag"}, 64'(got_byp[i]), 64'(exp_byp));
            check(got_last[i] == (i == exp_n - 1), "R9", {name, " last flag"},
                  64'(got_last[i]), 64'(i == exp_n - 1));
        end
        last_got = got;
        last_byp = (got > 0) ? got_byp[0] : 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_addr  = '0;
        in_mask  = '0;
        in_warps = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_ready === 1'b1, "R1", "reset in_ready", 64'(in_ready), 64'd1);
        check(req_valid === 1'b0, "R1", "reset req_valid", 64'(req_valid), 64'd0);
        rst_n = 1'b1;

        // table walk: R2..R10 across counts at and around the allowance (R4 boundary cases)
        for (int v = 0; v < NVEC; v++) begin
            for (int l = 0; l < LANES; l++)
                lane_addr[l] = VECS[v].base + 32'(l) * VECS[v].stride;
            run_instr($sformatf("vec%0d", v), VECS[v].mask, int'(VECS[v].warps));
            check(last_got == int'(VECS[v].n), "R8", $sformatf("vec%0d table count", v),
                  64'(last_got), 64'(VECS[v].n));
            if (VECS[v].n != 0)
                check(last_byp == VECS[v].byp, "R4", $sformatf("vec%0d table decision", v),
                      64'(last_byp), 64'(VECS[v].byp));
        end

        // R3: two lines interleaved across lanes, higher address on lane 0
        for (int l = 0; l < LANES; l++)
            lane_addr[l] = (l % 2 == 0) ? 32'h0000_E1E0 : 32'h0000_E040;
        run_instr("interleave", 32'hFFFF_FFFF, 64);
        run_instr("odd_only", 32'hAAAA_AAAA, 64);

        // R1: reset in the middle of an emission burst
        for (int l = 0; l < LANES; l++) lane_addr[l] = 32'h0001_0000 + 32'(l) * 32'd128;
        @(negedge clk);
        for (int l = 0; l < LANES; l++) in_addr[l*ADDR_W +: ADDR_W] = lane_addr[l];
        in_mask  = '1;
        in_warps = 7'd64;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (36) @(negedge clk);
        check(req_valid === 1'b1, "R9", "burst in progress", 64'(req_valid), 64'd1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(req_valid === 1'b0, "R1", "mid-burst reset req_valid", 64'(req_valid), 64'd0);
        check(in_ready === 1'b1, "R1", "mid-burst reset in_ready", 64'(in_ready), 64'd1);
        rst_n = 1'b1;

        // back to normal operation after the abort
        run_instr("after_reset", 32'h0000_0003, 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule